// File: doc/BRIEF.md
# Bit-Addressable Scratchpad RAM with Stack

This block is the 128-byte internal working memory of a small 8-bit controller core. One storage array answers three kinds of access. Byte accesses take a 7-bit byte address. Bit accesses take a 7-bit bit number that lands in a 16-byte window starting at byte 20h. Push and pop use an internal stack pointer, so the stack also lives in the same array. A separate input selects bit or byte mode, so one numeric address names different locations in the two modes.

The stack pointer can be read and loaded through a special-function-register port at address 81h. A helper output combines a two-bit bank number with a three-bit register index to form the byte address of a register operand in one of the four eight-byte banks at 00h–1Fh. The core uses that address on the byte port.

Top module: `sp_scratch_ram`

## Requirements
- R1: After reset every byte holds 00h, the stack pointer reads 07h, and rdata_o, pop_data_o and wrap_o are 0.
- R2: A byte read (req_i=1, we_i=0, bit_mode_i=0) presents the addressed byte on rdata_o after the next rising edge. It returns the contents from before any write in the same cycle. rdata_o holds its value when no read is requested. A byte write (req_i=1, we_i=1) stores wdata_i.
- R3: In bit mode, bit number n selects bit n&7 of byte 20h+(n>>3). A bit read returns that bit in rdata_o[0] with rdata_o[7:1]=0.
- R4: A bit write sets the selected bit to wbit_i in one cycle and leaves the other seven bits of that byte unchanged.
- R5: With sfr_addr_i=81h, sfr_rdata_o shows {0, stack pointer} in the same cycle, and sfr_we_i loads sfr_wdata_i[6:0] into the stack pointer at the next edge. At any other SFR address sfr_rdata_o is 00h and writes have no effect.
- R6: A push first increments the stack pointer and then writes push_data_i at the new location, so the first push after reset writes byte 08h.
- R7: A pop presents the byte at the current stack pointer on pop_data_o after the next edge and then decrements the pointer. pop_data_o holds between pops.
- R8: The stack pointer wraps modulo 128. A push at 7Fh writes byte 00h, and a pop at 00h leaves 7Fh. In either case wrap_o is 1 for exactly the following cycle.
- R9: reg_addr_o equals {bank_sel_i, reg_idx_i} (two zero bits, bank, index) combinationally.
- R10: A push takes priority. A same-cycle byte or bit write is ignored, a same-cycle pop is ignored, and a same-cycle SFR load of the stack pointer is ignored. A pop also blocks a same-cycle SFR load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Byte/bit access request |
| we_i | input | 1 | Access is a write |
| bit_mode_i | input | 1 | 1: addr_i is a bit number; 0: byte address |
| addr_i | input | 7 | Byte address or bit number |
| wdata_i | input | 8 | Byte write data |
| wbit_i | input | 1 | Bit write value |
| rdata_o | output | 8 | Registered read data |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| push_data_i | input | 8 | Byte to push |
| pop_data_o | output | 8 | Registered popped byte |
| wrap_o | output | 1 | One-cycle pulse after stack pointer wrap |
| sfr_we_i | input | 1 | SFR write strobe |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| bank_sel_i | input | 2 | Register bank number |
| reg_idx_i | input | 3 | Register index within bank |
| reg_addr_o | output | 7 | Bank-relative byte address |

## Verification
A wrong stack pointer shows on the SFR read port in the cycle right after the edge that corrupts it. Its later effects show on pop_data_o and on where pushed bytes land. A corrupted byte, or a bit write that spills into its neighbours, stays hidden until that byte is read back, so the bench mixes frequent byte and bit reads into a random operation stream. Every output is compared with a behavioural model on every cycle, which catches any divergence one cycle after it becomes visible. Directed sequences cover the aliasing between bit numbers and bytes 20h–2Fh, LIFO order, wrap in both directions and the three priority collisions.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned SP_AW         = 7;
  localparam int unsigned SP_DW         = 8;
  localparam int unsigned SP_BANK_W     = 2;
  localparam int unsigned SP_IDX_W      = 3;
  localparam int unsigned SP_BSEL_W     = $clog2(SP_DW);
  localparam logic [SP_AW-1:0] SP_BITWIN_BASE = 7'h20;
  localparam logic [7:0]       SP_SFR_ADDR    = 8'h81;
  localparam logic [SP_AW-1:0] SP_RESET_VAL   = 7'h07;

  typedef struct packed {
    logic             en;
    logic [SP_AW-1:0] addr;
    logic [SP_DW-1:0] data;
    logic [SP_DW-1:0] mask;
  } sp_wr_t;
endpackage

// File: rtl/sp_bank_addr.sv
module sp_bank_addr #(
  parameter int unsigned AW     = sp_pkg::SP_AW,
  parameter int unsigned BANK_W = sp_pkg::SP_BANK_W,
  parameter int unsigned IDX_W  = sp_pkg::SP_IDX_W
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [AW-1:0]     addr_o
);
  localparam int unsigned PAD_W = AW - BANK_W - IDX_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_o = {{PAD_W{1'b0}}, bank_i, idx_i};
    end else begin : g_nopad
      assign addr_o = {bank_i, idx_i};
    end
  endgenerate
endmodule

// File: rtl/sp_stack_ptr.sv
module sp_stack_ptr #(
  parameter int unsigned          AW      = sp_pkg::SP_AW,
  parameter logic [AW-1:0]        RST_VAL = sp_pkg::SP_RESET_VAL
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] push_addr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] SP_TOP = {AW{1'b1}};

  logic [AW-1:0] sp_q;
  logic          wrap_q;

  assign push_addr_o = sp_q + AW'(1);
  assign sp_o        = sp_q;
  assign wrap_o      = wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q   <= RST_VAL;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= (push_i && sp_q == SP_TOP) || (pop_i && sp_q == '0);
      if (push_i)     sp_q <= push_addr_o;
      else if (pop_i) sp_q <= sp_q - AW'(1);
      else if (ld_i)  sp_q <= ld_val_i;
    end
  end

  a_r6_push_increments: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp_q == $past(sp_q) + AW'(1));
  a_r7_pop_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> sp_q == $past(sp_q) - AW'(1));
  a_r8_wrap_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && sp_q == SP_TOP) |=> (wrap_o && sp_q == '0));
  a_r8_wrap_only_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !pop_i) |=> !wrap_o);
endmodule

// File: rtl/sp_byte_array.sv
module sp_byte_array
  import sp_pkg::*;
#(
  parameter int unsigned AW = SP_AW,
  parameter int unsigned DW = SP_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sp_wr_t        wr_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] stk_addr_i,
  output logic [DW-1:0] stk_data_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  assign rd_data_o  = mem_q[rd_addr_i];
  assign stk_data_o = mem_q[stk_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_i.en) begin
      mem_q[wr_i.addr] <= (mem_q[wr_i.addr] & ~wr_i.mask) | (wr_i.data & wr_i.mask);
    end
  end

  // checker state: the write of the previous cycle
  logic          chk_v_q;
  logic [AW-1:0] chk_addr_q;
  logic [DW-1:0] chk_mask_q, chk_old_q, chk_data_q;
  logic [DW-1:0] chk_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q    <= 1'b0;
      chk_addr_q <= '0;
      chk_mask_q <= '0;
      chk_old_q  <= '0;
      chk_data_q <= '0;
    end else begin
      chk_v_q    <= wr_i.en;
      chk_addr_q <= wr_i.addr;
      chk_mask_q <= wr_i.mask;
      chk_old_q  <= mem_q[wr_i.addr];
      chk_data_q <= wr_i.data;
    end
  end

  assign chk_now = mem_q[chk_addr_q];

  a_r4_unmasked_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_v_q |-> ((chk_now ^ chk_old_q) & ~chk_mask_q) == '0);
  a_r4_masked_bits_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_v_q |-> ((chk_now ^ chk_data_q) & chk_mask_q) == '0);
endmodule

// File: rtl/sp_scratch_ram.sv
module sp_scratch_ram
  import sp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             bit_mode_i,
  input  logic [SP_AW-1:0] addr_i,
  input  logic [SP_DW-1:0] wdata_i,
  input  logic             wbit_i,
  output logic [SP_DW-1:0] rdata_o,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [SP_DW-1:0] push_data_i,
  output logic [SP_DW-1:0] pop_data_o,
  output logic             wrap_o,
  input  logic             sfr_we_i,
  input  logic [7:0]       sfr_addr_i,
  input  logic [7:0]       sfr_wdata_i,
  output logic [7:0]       sfr_rdata_o,
  input  logic [SP_BANK_W-1:0] bank_sel_i,
  input  logic [SP_IDX_W-1:0]  reg_idx_i,
  output logic [SP_AW-1:0]     reg_addr_o
);
  localparam int unsigned BYTE_SEL_W = SP_AW - SP_BSEL_W;

  logic             pop_go, wr_go, rd_go, ld_go, sfr_hit;
  logic [SP_AW-1:0] sp, push_addr, bit_byte, rd_addr;
  logic [SP_BSEL_W-1:0] bit_sel;
  logic [SP_DW-1:0] rd_byte, stk_byte, bit_mask;
  logic [SP_DW-1:0] rdata_q, pop_q;
  sp_wr_t           wr;

  // push wins over pop, writes and SP loads
  assign sfr_hit = (sfr_addr_i == SP_SFR_ADDR);
  assign pop_go  = pop_i & ~push_i;
  assign wr_go   = req_i & we_i & ~push_i;
  assign rd_go   = req_i & ~we_i;
  assign ld_go   = sfr_we_i & sfr_hit & ~push_i & ~pop_i;

  assign bit_sel  = addr_i[SP_BSEL_W-1:0];
  assign bit_byte = SP_BITWIN_BASE | SP_AW'(addr_i[SP_AW-1:SP_BSEL_W]);
  assign bit_mask = SP_DW'(1) << bit_sel;
  assign rd_addr  = bit_mode_i ? bit_byte : addr_i;

  always_comb begin
    wr.en = push_i | wr_go;
    if (push_i) begin
      wr.addr = push_addr;
      wr.data = push_data_i;
      wr.mask = '1;
    end else if (bit_mode_i) begin
      wr.addr = bit_byte;
      wr.data = {SP_DW{wbit_i}};
      wr.mask = bit_mask;
    end else begin
      wr.addr = addr_i;
      wr.data = wdata_i;
      wr.mask = '1;
    end
  end

  sp_stack_ptr #(.AW(SP_AW), .RST_VAL(SP_RESET_VAL)) u_sp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_go),
    .ld_i        (ld_go),
    .ld_val_i    (sfr_wdata_i[SP_AW-1:0]),
    .sp_o        (sp),
    .push_addr_o (push_addr),
    .wrap_o      (wrap_o)
  );

  sp_byte_array #(.AW(SP_AW), .DW(SP_DW)) u_mem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr),
    .rd_addr_i  (rd_addr),
    .rd_data_o  (rd_byte),
    .stk_addr_i (sp),
    .stk_data_o (stk_byte)
  );

  sp_bank_addr #(.AW(SP_AW), .BANK_W(SP_BANK_W), .IDX_W(SP_IDX_W)) u_bank (
    .bank_i (bank_sel_i),
    .idx_i  (reg_idx_i),
    .addr_o (reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      pop_q   <= '0;
    end else begin
      if (rd_go) rdata_q <= bit_mode_i ? SP_DW'(rd_byte[bit_sel]) : rd_byte;
      if (pop_go) pop_q <= stk_byte;
    end
  end

  assign rdata_o     = rdata_q;
  assign pop_data_o  = pop_q;
  assign sfr_rdata_o = sfr_hit ? 8'(sp) : 8'h00;

  a_r5_foreign_sfr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sfr_hit && !push_i && !pop_i) |=> sp == $past(sp));
  a_r10_push_blocks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> sp == $past(push_addr));
  a_r3_bit_read_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_go && bit_mode_i) |=> rdata_o[SP_DW-1:1] == '0);
  a_r2_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_go |=> $stable(rdata_o));
  a_r7_pop_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pop_go |=> $stable(pop_data_o));
endmodule

// File: tb/sp_scratch_ram_bench.sv
module sp_scratch_ram_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 0, we_i = 0, bit_mode_i = 0, wbit_i = 0;
  logic [6:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       push_i = 0, pop_i = 0;
  logic [7:0] push_data_i = '0, pop_data_o;
  logic       wrap_o;
  logic       sfr_we_i = 0;
  logic [7:0] sfr_addr_i = 8'h81, sfr_wdata_i = '0, sfr_rdata_o;
  logic [1:0] bank_sel_i = '0;
  logic [2:0] reg_idx_i = '0;
  logic [6:0] reg_addr_o;

  always #4 clk_i = ~clk_i;

  sp_scratch_ram u_sp_scratch_ram (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // reference model
  logic [7:0] m_mem [128];
  int         m_sp;
  int         e_rdata, e_pop, e_wrap;
  string      rd_tag = "R2";

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
    m_sp = 7; e_rdata = 0; e_pop = 0; e_wrap = 0;
  endtask

  task automatic tick();
    bit p, po, w, rd, ld;
    int bb, bi;
    p  = push_i;
    po = pop_i && !p;
    w  = req_i && we_i && !p;
    rd = req_i && !we_i;
    ld = sfr_we_i && sfr_addr_i == 8'h81 && !p && !po;
    bb = 32 + (addr_i / 8);
    bi = addr_i % 8;
    if (rd) begin
      if (bit_mode_i) begin e_rdata = (m_mem[bb] >> bi) & 1; rd_tag = "R3"; end
      else begin e_rdata = m_mem[addr_i]; rd_tag = "R2"; end
    end
    if (po) e_pop = m_mem[m_sp];
    e_wrap = (p && m_sp == 127) || (po && m_sp == 0);
    if (p) m_mem[(m_sp + 1) % 128] = push_data_i;
    else if (w) begin
      if (bit_mode_i) begin
        if (wbit_i) m_mem[bb] = m_mem[bb] | (8'h01 << bi);
        else        m_mem[bb] = m_mem[bb] & ~(8'h01 << bi);
      end else m_mem[addr_i] = wdata_i;
    end
    if (p) m_sp = (m_sp + 1) % 128;
    else if (po) m_sp = (m_sp + 127) % 128;
    else if (ld) m_sp = sfr_wdata_i % 128;
    @(posedge clk_i);
    @(negedge clk_i);
    check(rd_tag, rdata_o, e_rdata);
    check("R7", pop_data_o, e_pop);
    check("R8", wrap_o, e_wrap);
    check("R5", sfr_rdata_o, (sfr_addr_i == 8'h81) ? m_sp : 0);
    check("R9", reg_addr_o, {bank_sel_i, reg_idx_i});
    req_i = 0; we_i = 0; push_i = 0; pop_i = 0; sfr_we_i = 0;
  endtask

  task automatic wr_byte(logic [6:0] a, logic [7:0] d);
    req_i = 1; we_i = 1; bit_mode_i = 0; addr_i = a; wdata_i = d; tick();
  endtask
  task automatic rd_byte(logic [6:0] a);
    req_i = 1; we_i = 0; bit_mode_i = 0; addr_i = a; tick();
  endtask
  task automatic wr_bit(logic [6:0] n, logic v);
    req_i = 1; we_i = 1; bit_mode_i = 1; addr_i = n; wbit_i = v; tick();
  endtask
  task automatic rd_bit(logic [6:0] n);
    req_i = 1; we_i = 0; bit_mode_i = 1; addr_i = n; tick();
  endtask
  task automatic do_push(logic [7:0] d);
    push_i = 1; push_data_i = d; tick();
  endtask
  task automatic do_pop();
    pop_i = 1; tick();
  endtask
  task automatic ld_sp(logic [7:0] v);
    sfr_we_i = 1; sfr_addr_i = 8'h81; sfr_wdata_i = v; tick();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    #20; @(negedge clk_i); rst_ni = 1; @(negedge clk_i);
    // R1: reset state
    check("R1", sfr_rdata_o, 8'h07);
    check("R1", rdata_o, 0);
    check("R1", pop_data_o, 0);
    check("R1", wrap_o, 0);
    rd_byte(7'h08); check("R1", rdata_o, 0);
    rd_byte(7'h7f); check("R1", rdata_o, 0);

    // R2: byte write/read, read-before-write, hold
    wr_byte(7'h00, 8'h3c); wr_byte(7'h7f, 8'hc3); wr_byte(7'h45, 8'h5a);
    rd_byte(7'h00); check("R2", rdata_o, 8'h3c);
    rd_byte(7'h7f); check("R2", rdata_o, 8'hc3);
    tick(); check("R2", rdata_o, 8'hc3);
    rd_byte(7'h45); check("R2", rdata_o, 8'h5a);

    // R3: bit aliasing into 20h-2Fh
    wr_byte(7'h21, 8'ha5);
    rd_bit(7'h08); check("R3", rdata_o, 1);
    rd_bit(7'h09); check("R3", rdata_o, 0);
    rd_bit(7'h0f); check("R3", rdata_o, 1);
    wr_byte(7'h2f, 8'h80);
    rd_bit(7'h7f); check("R3", rdata_o, 1);
    rd_bit(7'h7e); check("R3", rdata_o, 0);

    // R4: bit write leaves neighbours
    wr_byte(7'h20, 8'hff);
    wr_bit(7'h03, 1'b0); rd_byte(7'h20); check("R4", rdata_o, 8'hf7);
    wr_bit(7'h00, 1'b0); rd_byte(7'h20); check("R4", rdata_o, 8'hf6);
    wr_bit(7'h7e, 1'b1); rd_byte(7'h2f); check("R4", rdata_o, 8'hc0);
    rd_byte(7'h2e); check("R4", rdata_o, 8'h00);

    // R6 / R7: push then pop, LIFO
    do_push(8'h11); check("R6", sfr_rdata_o, 8'h08);
    do_push(8'h22); do_push(8'h33);
    rd_byte(7'h08); check("R6", rdata_o, 8'h11);
    rd_byte(7'h0a); check("R6", rdata_o, 8'h33);
    do_pop(); check("R7", pop_data_o, 8'h33);
    do_pop(); check("R7", pop_data_o, 8'h22);
    do_pop(); check("R7", pop_data_o, 8'h11); check("R7", sfr_rdata_o, 8'h07);

    // R5: SFR port
    ld_sp(8'hff); check("R5", sfr_rdata_o, 8'h7f);
    sfr_we_i = 1; sfr_addr_i = 8'h80; sfr_wdata_i = 8'h10; tick();
    check("R5", sfr_rdata_o, 8'h00);
    sfr_addr_i = 8'h81; tick(); check("R5", sfr_rdata_o, 8'h7f);

    // R8: wrap both ways
    do_push(8'h99); check("R8", wrap_o, 1); check("R8", sfr_rdata_o, 8'h00);
    tick(); check("R8", wrap_o, 0);
    rd_byte(7'h00); check("R8", rdata_o, 8'h99);
    do_pop(); check("R8", wrap_o, 1); check("R8", sfr_rdata_o, 8'h7f);
    check("R8", pop_data_o, 8'h99);

    // R10: push priority
    ld_sp(8'h30);
    push_i = 1; push_data_i = 8'hab; req_i = 1; we_i = 1; bit_mode_i = 0;
    addr_i = 7'h50; wdata_i = 8'hee; tick();
    rd_byte(7'h50); check("R10", rdata_o, 8'h00);
    rd_byte(7'h31); check("R10", rdata_o, 8'hab);
    push_i = 1; push_data_i = 8'hcd; pop_i = 1; tick();
    check("R10", sfr_rdata_o, 8'h32);
    push_i = 1; push_data_i = 8'h01; sfr_we_i = 1; sfr_wdata_i = 8'h05; tick();
    check("R10", sfr_rdata_o, 8'h33);
    pop_i = 1; sfr_we_i = 1; sfr_wdata_i = 8'h05; tick();
    check("R10", sfr_rdata_o, 8'h32);
    push_i = 1; push_data_i = 8'h77; req_i = 1; we_i = 1; bit_mode_i = 1;
    addr_i = 7'h10; wbit_i = 1; tick();
    rd_byte(7'h22); check("R10", rdata_o, 8'h00);

    // R9: bank address sweep
    for (int b = 0; b < 4; b++)
      for (int i = 0; i < 8; i++) begin
        bank_sel_i = 2'(b); reg_idx_i = 3'(i); #1;
        check("R9", reg_addr_o, b * 8 + i);
      end

    // mixed random stream against the model
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      push_i = r[0] & r[1];
      pop_i = r[2] & r[3];
      req_i = r[4] | r[27];
      we_i = r[5];
      bit_mode_i = r[6];
      addr_i = (r[28] && !r[6]) ? (7'h20 | 7'(r[10:7])) : r[13:7];
      wdata_i = r[21:14];
      wbit_i = r[22];
      push_data_i = 8'($urandom);
      sfr_we_i = r[23] & r[24] & r[25];
      sfr_addr_i = r[26] ? 8'h81 : 8'($urandom);
      sfr_wdata_i = 8'($urandom);
      bank_sel_i = r[30:29];
      reg_idx_i = 3'($urandom);
      tick();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule